// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit evaluates the bit-oriented instructions of an 8-bit accumulator processor. In one clock it takes a decoded operation, the accumulator, the memory operand already fetched by the core, a bit index, an immediate-mode indicator, a relative branch displacement and the program counter of the following instruction. One cycle later it presents the result on registered outputs.

Seven operations are supported:

- a flag-only test of the operand against the accumulator;
- two read-modify-write forms that clear or set the accumulator's bits in the operand;
- forcing one chosen operand bit to 1 or to 0;
- a conditional branch on one chosen operand bit, either when the bit is set or when it is clear.

The core writes `wr_data` back to the operand's address when `wr_en` is high. It loads each of N, V and Z only when that flag's update enable is high, so any flag an operation leaves alone keeps its old value. It loads the program counter from `br_target` when `br_taken` is high. The core does the fetch, the address generation and the memory access itself.

Top module: `bitop_unit`

## Requirements
- R1: While reset is asserted, and until the first accepted operation, `res_valid`, `wr_en`, `upd_n`, `upd_v`, `upd_z` and `br_taken` are all 0.
- R2: An operation sampled with `op_valid` high at a rising edge produces its results on the outputs after that edge, with `res_valid` high. A cycle with `op_valid` low gives `res_valid`, `wr_en`, all update enables and `br_taken` low after the following edge.
- R3: Code 0 (test) asserts `upd_z`, with `flag_z` high exactly when (operand AND accumulator) is zero. It never asserts `wr_en` or `br_taken`.
- R4: For code 0 with `imm_mode` low, `upd_n` and `upd_v` are high, and `flag_n`/`flag_v` equal operand bit 7 and bit 6. With `imm_mode` high, `upd_n` and `upd_v` stay low.
- R5: Code 1 (test-and-reset) asserts `wr_en` with `wr_data` = operand AND NOT accumulator. It asserts only `upd_z`, with Z computed as in R3.
- R6: Code 2 (test-and-set) asserts `wr_en` with `wr_data` = operand OR accumulator. It asserts only `upd_z`, with Z computed as in R3.
- R7: Code 3 (set bit) and code 4 (clear bit) assert `wr_en`. `wr_data` is the operand with bit `bit_sel` forced to 1 or to 0 respectively. No flag update enable is asserted.
- R8: Code 5 branches (`br_taken` high) when operand bit `bit_sel` is 1, and code 6 branches when it is 0. Neither asserts `wr_en` or any flag update enable.
- R9: For codes 5 and 6, `br_target` equals `pc_next` plus the sign-extended 8-bit `br_ofs`, wrapping modulo 2^16.
- R10: Code 7 is reserved. It gives `res_valid` high with `wr_en`, all update enables and `br_taken` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation code (0 test, 1 test-reset, 2 test-set, 3 set bit, 4 clear bit, 5 branch if set, 6 branch if clear, 7 reserved) |
| bit_sel | input | 3 | Selected operand bit |
| acc | input | 8 | Accumulator value |
| operand | input | 8 | Memory operand (for branches, the zero-page byte) |
| imm_mode | input | 1 | Operand came from the immediate addressing mode |
| br_ofs | input | 8 | Signed relative branch displacement |
| pc_next | input | 16 | Program counter of the following instruction |
| res_valid | output | 1 | Result registers hold a new result |
| wr_en | output | 1 | Write-back strobe |
| wr_data | output | 8 | Value to write back |
| flag_n | output | 1 | New N value |
| flag_v | output | 1 | New V value |
| flag_z | output | 1 | New Z value |
| upd_n | output | 1 | Load N |
| upd_v | output | 1 | Load V |
| upd_z | output | 1 | Load Z |
| br_taken | output | 1 | Branch condition met |
| br_target | output | 16 | Branch destination |

## Verification
The test-and-set and test-and-reset operations drive the write-back strobe and the Z flag update in the same cycle. The bench issues them back to back, with operand and accumulator pairs chosen so that Z and the written value disagree in both directions. Each result is judged against a scoreboard entry computed from the inputs. The bench also places operations right after one another and next to idle cycles, so a new capture and the strobe clearing from the previous one share an edge. These cases show whether stale write, flag or branch strobes leak into the next cycle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [2:0] {
    BOP_TEST = 3'd0,
    BOP_TRST = 3'd1,
    BOP_TSET = 3'd2,
    BOP_SETB = 3'd3,
    BOP_CLRB = 3'd4,
    BOP_BRS  = 3'd5,
    BOP_BRC  = 3'd6,
    BOP_RSVD = 3'd7
  } bop_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
  } nvz_t;

endpackage

// File: rtl/bitop_logic.sv
module bitop_logic
  import bitop_pkg::*;
#(
  parameter int DW = 8
) (
  input  bop_e                  op,
  input  logic [$clog2(DW)-1:0] sel,
  input  logic [DW-1:0]         acc,
  input  logic [DW-1:0]         opnd,
  input  logic                  imm,
  output logic                  wr_req,
  output logic [DW-1:0]         wr_val,
  output nvz_t                  fl_val,
  output nvz_t                  fl_en
);

  localparam int SW = $clog2(DW);

  logic [DW-1:0] mask;
  logic          z_hit;

  // one-hot decode of the selected bit
  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (sel == SW'(i));
  end

  assign z_hit = ~|(opnd & acc);

  always_comb begin
    fl_val.n = opnd[DW-1];
    fl_val.v = opnd[DW-2];
    fl_val.z = z_hit;
  end

  always_comb begin
    wr_req = 1'b0;
    wr_val = opnd;
    fl_en  = '0;
    case (op)
      BOP_TEST: begin
        fl_en.z = 1'b1;
        fl_en.n = ~imm;
        fl_en.v = ~imm;
      end
      BOP_TRST: begin
        wr_req  = 1'b1;
        wr_val  = opnd & ~acc;
        fl_en.z = 1'b1;
      end
      BOP_TSET: begin
        wr_req  = 1'b1;
        wr_val  = opnd | acc;
        fl_en.z = 1'b1;
      end
      BOP_SETB: begin
        wr_req = 1'b1;
        wr_val = opnd | mask;
      end
      BOP_CLRB: begin
        wr_req = 1'b1;
        wr_val = opnd & ~mask;
      end
      default: begin
        wr_req = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bitop_branch.sv
module bitop_branch
  import bitop_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  bop_e                  op,
  input  logic [$clog2(DW)-1:0] sel,
  input  logic [DW-1:0]         opnd,
  input  logic [OW-1:0]         ofs,
  input  logic [AW-1:0]         pc,
  output logic                  take,
  output logic [AW-1:0]         target
);

  logic          tested;
  logic [AW-1:0] ofs_ext;

  assign tested  = opnd[sel];
  assign ofs_ext = {{(AW-OW){ofs[OW-1]}}, ofs};
  assign target  = pc + ofs_ext;

  always_comb begin
    case (op)
      BOP_BRS: take = tested;
      BOP_BRC: take = ~tested;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 16,
  parameter int OFS_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  input  logic [2:0]                op_code,
  input  logic [$clog2(DATA_W)-1:0] bit_sel,
  input  logic [DATA_W-1:0]         acc,
  input  logic [DATA_W-1:0]         operand,
  input  logic                      imm_mode,
  input  logic [OFS_W-1:0]          br_ofs,
  input  logic [PC_W-1:0]           pc_next,
  output logic                      res_valid,
  output logic                      wr_en,
  output logic [DATA_W-1:0]         wr_data,
  output logic                      flag_n,
  output logic                      flag_v,
  output logic                      flag_z,
  output logic                      upd_n,
  output logic                      upd_v,
  output logic                      upd_z,
  output logic                      br_taken,
  output logic [PC_W-1:0]           br_target
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  bop_e              op_e;
  logic              wr_req;
  logic [DATA_W-1:0] wr_val;
  nvz_t              fl_val, fl_en;
  logic              take;
  logic [PC_W-1:0]   target;

  assign op_e = bop_e'(op_code);

  bitop_logic #(.DW(DATA_W)) u_logic (
    .op     (op_e),
    .sel    (bit_sel),
    .acc    (acc),
    .opnd   (operand),
    .imm    (imm_mode),
    .wr_req (wr_req),
    .wr_val (wr_val),
    .fl_val (fl_val),
    .fl_en  (fl_en)
  );

  bitop_branch #(.DW(DATA_W), .AW(PC_W), .OW(OFS_W)) u_branch (
    .op     (op_e),
    .sel    (bit_sel),
    .opnd   (operand),
    .ofs    (br_ofs),
    .pc     (pc_next),
    .take   (take),
    .target (target)
  );

  // next state
  logic              valid_d, wr_en_d, br_taken_d;
  nvz_t              upd_d, flag_d;
  logic [DATA_W-1:0] wr_data_d;
  logic [PC_W-1:0]   br_target_d;

  always_comb begin
    valid_d     = op_valid;
    wr_en_d     = op_valid & wr_req;
    upd_d       = op_valid ? fl_en : '0;
    br_taken_d  = op_valid & take;
    wr_data_d   = op_valid ? wr_val : wr_data;
    flag_d      = op_valid ? fl_val : nvz_t'({flag_n, flag_v, flag_z});
    br_target_d = op_valid ? target : br_target;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_valid <= 1'b0;
      wr_en     <= 1'b0;
      upd_n     <= 1'b0;
      upd_v     <= 1'b0;
      upd_z     <= 1'b0;
      br_taken  <= 1'b0;
      wr_data   <= '0;
      flag_n    <= 1'b0;
      flag_v    <= 1'b0;
      flag_z    <= 1'b0;
      br_target <= '0;
    end else begin
      res_valid <= valid_d;
      wr_en     <= wr_en_d;
      upd_n     <= upd_d.n;
      upd_v     <= upd_d.v;
      upd_z     <= upd_d.z;
      br_taken  <= br_taken_d;
      wr_data   <= wr_data_d;
      flag_n    <= flag_d.n;
      flag_v    <= flag_d.v;
      flag_z    <= flag_d.z;
      br_target <= br_target_d;
    end
  end

  // checks against the port behaviour
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !op_valid |=> !res_valid && !wr_en && !upd_n && !upd_v && !upd_z && !br_taken);

  p_test_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    op_valid && op_code == 3'd0 |=> upd_z && !wr_en && !br_taken
      && (flag_z == (($past(operand) & $past(acc)) == '0)));

  p_test_imm_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    op_valid && op_code == 3'd0 && imm_mode |=> !upd_n && !upd_v);

  p_test_nv_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    op_valid && op_code == 3'd0 && !imm_mode |=> upd_n && upd_v
      && flag_n == $past(operand[DATA_W-1]) && flag_v == $past(operand[DATA_W-2]));

  p_trst_clear_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    op_valid && op_code == 3'd1 |=> wr_en && ((wr_data & $past(acc)) == '0) && !upd_n);

  p_tset_cover_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    op_valid && op_code == 3'd2 |=> wr_en && ((wr_data & $past(acc)) == $past(acc)) && !upd_v);

  p_setb_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    op_valid && op_code == 3'd3 |=> wr_en && wr_data[$past(bit_sel)] && !upd_z);

  p_clrb_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    op_valid && op_code == 3'd4 |=> wr_en && !wr_data[$past(bit_sel)] && !upd_z);

  p_branch_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    op_valid && (op_code == 3'd5 || op_code == 3'd6)
      |=> !wr_en && !upd_n && !upd_v && !upd_z);

  p_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    op_valid && op_code == 3'd7 |=> res_valid && !wr_en && !upd_z && !br_taken);

endmodule

// File: tb/bitop_unit_tb_top.sv
`timescale 1ns/1ps
module bitop_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [2:0]  bit_sel;
  logic [7:0]  acc, operand;
  logic        imm_mode;
  logic [7:0]  br_ofs;
  logic [15:0] pc_next;
  logic        res_valid, wr_en, flag_n, flag_v, flag_z;
  logic        upd_n, upd_v, upd_z, br_taken;
  logic [7:0]  wr_data;
  logic [15:0] br_target;

  always #2.5 clk = ~clk;

  bitop_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .bit_sel(bit_sel), .acc(acc), .operand(operand), .imm_mode(imm_mode),
    .br_ofs(br_ofs), .pc_next(pc_next), .res_valid(res_valid), .wr_en(wr_en),
    .wr_data(wr_data), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z),
    .upd_n(upd_n), .upd_v(upd_v), .upd_z(upd_z), .br_taken(br_taken),
    .br_target(br_target)
  );

  typedef struct {
    bit          vld, wr, un, uv, uz, bt, ctgt;
    bit [7:0]    wd;
    bit          n, v, z;
    bit [15:0]   tgt;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;

  // expected result, from the requirements
  function automatic exp_t model(bit v, bit [2:0] c, bit [2:0] s, bit [7:0] a,
                                 bit [7:0] o, bit im, bit [7:0] f, bit [15:0] p,
                                 string tag);
    exp_t e;
    e = '{default: 0, tag: tag};
    e.vld = v;
    if (!v) return e;
    e.n = o[7];
    e.v = o[6];
    e.z = ((o & a) == 8'h00);
    case (c)
      3'd0: begin e.uz = 1; e.un = !im; e.uv = !im; end
      3'd1: begin e.uz = 1; e.wr = 1; e.wd = o & ~a; end
      3'd2: begin e.uz = 1; e.wr = 1; e.wd = o | a; end
      3'd3: begin e.wr = 1; e.wd = o | (8'h01 << s); end
      3'd4: begin e.wr = 1; e.wd = o & ~(8'h01 << s); end
      3'd5: begin e.bt = o[s];  e.ctgt = 1; e.tgt = p + {{8{f[7]}}, f}; end
      3'd6: begin e.bt = !o[s]; e.ctgt = 1; e.tgt = p + {{8{f[7]}}, f}; end
      default: ;
    endcase
    return e;
  endfunction

  // driver: one cycle per call, pushes the expectation
  task automatic step(bit v, bit [2:0] c, bit [2:0] s, bit [7:0] a, bit [7:0] o,
                      bit im, bit [7:0] f, bit [15:0] p, string tag);
    @(negedge clk);
    op_valid = v; op_code = c; bit_sel = s; acc = a; operand = o;
    imm_mode = im; br_ofs = f; pc_next = p;
    sb_q.push_back(model(v, c, s, a, o, im, f, p, tag));
  endtask

  task automatic idle(string tag);
    step(0, 3'd0, 3'd0, 8'h00, 8'h00, 0, 8'h00, 16'h0000, tag);
  endtask

  // monitor: compares each result after the edge that produced it
  initial begin
    exp_t e;
    bit   bad;
    wait (mon_on);
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        bad = (res_valid != e.vld) || (wr_en != e.wr) || (upd_n != e.un) ||
              (upd_v != e.uv) || (upd_z != e.uz) || (br_taken != e.bt) ||
              (e.wr && wr_data != e.wd) || (e.un && flag_n != e.n) ||
              (e.uv && flag_v != e.v) || (e.uz && flag_z != e.z) ||
              (e.ctgt && br_target != e.tgt);
        n_chk++;
        if (bad) begin
          n_bad++;
          $display("FAIL %s actual vld=%b wr=%b wd=%h upd=%b%b%b nvz=%b%b%b bt=%b tgt=%h expected vld=%b wr=%b wd=%h upd=%b%b%b nvz=%b%b%b bt=%b tgt=%h",
                   e.tag, res_valid, wr_en, wr_data, upd_n, upd_v, upd_z,
                   flag_n, flag_v, flag_z, br_taken, br_target,
                   e.vld, e.wr, e.wd, e.un, e.uv, e.uz, e.n, e.v, e.z, e.bt, e.tgt);
        end
      end
    end
  end

  task automatic check_quiet(string tag);
    n_chk++;
    if (res_valid || wr_en || upd_n || upd_v || upd_z || br_taken) begin
      n_bad++;
      $display("FAIL %s actual vld=%b wr=%b upd=%b%b%b bt=%b expected all 0",
               tag, res_valid, wr_en, upd_n, upd_v, upd_z, br_taken);
    end
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 0; op_code = 0; bit_sel = 0; acc = 0; operand = 0;
    imm_mode = 0; br_ofs = 0; pc_next = 0;
    // R1: quiet during reset, even with an operation offered
    repeat (3) @(negedge clk);
    check_quiet("R1");
    op_valid = 1; op_code = 3'd2; acc = 8'hFF;
    @(negedge clk);
    check_quiet("R1");
    op_valid = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("R1");
    mon_on = 1'b1;

    // R3/R4: test, non-immediate and immediate
    step(1, 3'd0, 0, 8'h3F, 8'hC0, 0, 0, 0, "R4");
    step(1, 3'd0, 0, 8'h01, 8'h41, 0, 0, 0, "R3");
    step(1, 3'd0, 0, 8'h00, 8'hFF, 1, 0, 0, "R4");
    step(1, 3'd0, 0, 8'h80, 8'h80, 1, 0, 0, "R3");
    // R5/R6: write and Z in the same result, back to back
    step(1, 3'd1, 0, 8'h3C, 8'hF0, 0, 0, 0, "R5");
    step(1, 3'd1, 0, 8'hF0, 8'h0F, 0, 0, 0, "R5");
    step(1, 3'd2, 0, 8'hF0, 8'h0F, 0, 0, 0, "R6");
    step(1, 3'd2, 0, 8'h01, 8'h81, 1, 0, 0, "R6");
    idle("R2");
    step(1, 3'd1, 0, 8'hFF, 8'hFF, 0, 0, 0, "R5");
    idle("R2");
    idle("R2");
    // R7: every bit position, both forms
    for (int i = 0; i < 8; i++) step(1, 3'd3, 3'(i), 8'hAA, 8'h00, 0, 0, 0, "R7");
    for (int i = 0; i < 8; i++) step(1, 3'd4, 3'(i), 8'h55, 8'hFF, 0, 0, 0, "R7");
    step(1, 3'd3, 3'd5, 8'h00, 8'h20, 1, 0, 0, "R7");
    // R8/R9: both polarities, wrap in both directions
    step(1, 3'd5, 3'd2, 8'h00, 8'h04, 0, 8'h10, 16'h1000, "R8");
    step(1, 3'd5, 3'd3, 8'h00, 8'h04, 0, 8'h10, 16'h1000, "R8");
    step(1, 3'd6, 3'd3, 8'h00, 8'h04, 0, 8'h80, 16'h0010, "R9");
    step(1, 3'd6, 3'd7, 8'hFF, 8'h7F, 0, 8'h7F, 16'hFFF0, "R9");
    step(1, 3'd6, 3'd0, 8'h00, 8'h01, 0, 8'hFE, 16'h2000, "R8");
    step(1, 3'd5, 3'd7, 8'h00, 8'h80, 0, 8'hFF, 16'h0000, "R9");
    // R10: reserved code
    step(1, 3'd7, 3'd1, 8'hFF, 8'hFF, 0, 8'h10, 16'h1234, "R10");
    idle("R2");
    step(1, 3'd7, 3'd0, 8'h00, 8'h00, 1, 0, 0, "R10");
    idle("R2");
    idle("R2");
    wait (sb_q.size() == 0);
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule